// File: doc/BRIEF.md
# Complementary PWM Buffered Cycle Timer

This block is the timebase for a center-aligned complementary PWM stage. It runs two up/down counters in lockstep. The cycle counter starts at the dead-time value and the carrier counter starts at zero, so the two always stay exactly one dead time apart. Both counters climb until either one meets its active upper limit (the crest), fall back until the carrier counter reaches zero (the trough), and then repeat. For a correct setup, the cycle limit equals the carrier limit plus the dead time.

Software never writes the active limits. It writes a cycle buffer, a carrier buffer and a dead-time register through a plain write port. The block copies both limit buffers into the active limits in one clock, at the event that the transfer mode selects.

- A copy taken at a crest shapes the carrier period that follows.
- A copy taken at a trough shapes the period that begins at that trough.

A combinational flag reports when the buffered pair does not satisfy the cycle = carrier + dead-time rule. A start input reloads the counters and limits. A stop input freezes both counters.

Top module: `cpwm_timebase`

## Requirements
- R1: While reset is asserted, both counters read 0, and the crest, trough, transfer and running outputs are 0.
- R2: A start pulse loads the cycle counter with the dead-time register, loads the carrier counter with 0, sets counting upward, sets running, and copies both buffers into the active limits. Start takes priority over stop.
- R3: While running and not stopped, both counters change by the same step on every clock, so their difference never changes. The one exception is a crest while the carrier counter is 0, where both counters hold.
- R4: The crest output is high for one clock when the block is running and rising and either the cycle counter is at or above its active limit or the carrier counter is at or above its active limit. On the next clock both counters count down.
- R5: The trough output is high for one clock when the block is running and falling and the carrier counter equals 0. On the next clock both counters count up.
- R6: The transfer mode input selects when limits are copied. Bit 0 set means copy at a crest. Bit 1 set means copy at a trough. 2'b11 means copy at both. 2'b00 means never copy. The transfer output pulses in every clock in which a copy happens.
- R7: Both active limits are loaded in the same clock. A crest copy sets the peak of the following carrier period. A trough copy sets the peak of the period starting at that trough.
- R8: A buffer write in the same clock as a copy is stored in the buffer, but the copy uses the previous buffer contents. The new value is used from the next copy onward.
- R9: The configuration error output is high exactly when the cycle buffer differs from the sum, modulo 2^W, of the carrier buffer and the dead-time register.
- R10: Stop clears running and freezes both counters, with crest and trough low, until the next start.
- R11: The write select field addresses one register: 0 selects the cycle buffer, 1 the carrier buffer and 2 the dead-time register. A write with select 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Load initial counts and limits, begin counting |
| stop | input | 1 | Freeze both counters |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 cycle buffer, 1 carrier buffer, 2 dead time |
| wr_data | input | W | Write data |
| xfer_mode | input | 2 | Copy timing: bit 0 crest, bit 1 trough |
| cnt_a | output | W | Cycle counter |
| cnt_b | output | W | Carrier counter |
| crest | output | 1 | Crest pulse |
| trough | output | 1 | Trough pulse |
| xfer | output | 1 | Buffer-to-active copy strobe |
| cfg_err | output | 1 | Buffered pair breaks cycle = carrier + dead time |
| running | output | 1 | Counters are active |

## Verification
The hardest situation to reach from the ports is a buffer write that falls in the very clock of a copy, because the crest can move whenever a limit changes. The bench keeps its own model of the counters and limits, predicts the crest before it drives each cycle, and places the write in exactly that clock. It then checks the peaks of the two periods that follow. Random writes, mode changes and stop/start pulses run around these directed cases, so that copies also land while the buffered pair is inconsistent.

// File: rtl/cpwm_timebase.sv
module cpwm_timebase #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         stop,
  input  logic         wr_en,
  input  logic [1:0]   wr_sel,
  input  logic [W-1:0] wr_data,
  input  logic [1:0]   xfer_mode,
  output logic [W-1:0] cnt_a,
  output logic [W-1:0] cnt_b,
  output logic         crest,
  output logic         trough,
  output logic         xfer,
  output logic         cfg_err,
  output logic         running
);

  localparam logic [W-1:0] STEP = W'(1);

  logic [W-1:0] buf_a, buf_b, buf_d;
  logic [W-1:0] lim_a, lim_b;
  logic         up;
  logic         advance;

  assign crest   = running && up && ((cnt_a >= lim_a) || (cnt_b >= lim_b));
  assign trough  = running && !up && (cnt_b == '0);
  assign xfer    = (crest && xfer_mode[0]) || (trough && xfer_mode[1]);
  assign cfg_err = buf_a != (buf_b + buf_d);
  assign advance = running && !stop && !start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_a <= '0;
      buf_b <= '0;
      buf_d <= '0;
    end else if (wr_en) begin
      case (wr_sel)
        2'd0:    buf_a <= wr_data;
        2'd1:    buf_b <= wr_data;
        2'd2:    buf_d <= wr_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lim_a <= '0;
      lim_b <= '0;
    end else if (start || xfer) begin
      lim_a <= buf_a;
      lim_b <= buf_b;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_a   <= '0;
      cnt_b   <= '0;
      up      <= 1'b0;
      running <= 1'b0;
    end else if (start) begin
      cnt_a   <= buf_d;
      cnt_b   <= '0;
      up      <= 1'b1;
      running <= 1'b1;
    end else begin
      if (stop) running <= 1'b0;
      if (advance) begin
        if (crest) begin
          up <= 1'b0;
          if (cnt_b != '0) begin
            cnt_a <= cnt_a - STEP;
            cnt_b <= cnt_b - STEP;
          end
        end else if (trough) begin
          up    <= 1'b1;
          cnt_a <= cnt_a + STEP;
          cnt_b <= cnt_b + STEP;
        end else if (up) begin
          cnt_a <= cnt_a + STEP;
          cnt_b <= cnt_b + STEP;
        end else begin
          cnt_a <= cnt_a - STEP;
          cnt_b <= cnt_b - STEP;
        end
      end
    end
  end

  AST_OFFSET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    advance |=> (cnt_a - cnt_b) == $past(cnt_a - cnt_b)); // R3
  AST_CREST_TURN: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && crest && cnt_b != '0) |=> cnt_a == $past(cnt_a) - STEP); // R4
  AST_TROUGH_TURN: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && trough) |=> cnt_b == STEP); // R5
  AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(crest && trough)); // R4
  AST_PAIR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && !start) |=> (lim_a == $past(buf_a)) && (lim_b == $past(buf_b))); // R7
  AST_LIMITS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer && !start) |=> $stable(lim_a) && $stable(lim_b)); // R8
  AST_STOP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !start) |=> $stable(cnt_a) && $stable(cnt_b) && !running); // R10

endmodule

// File: tb/cpwm_timebase_bench.sv
module cpwm_timebase_bench;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, stop = 1'b0, wr_en = 1'b0;
  logic [1:0] wr_sel = '0, xfer_mode = '0, mode_next = '0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] cnt_a, cnt_b;
  logic crest, trough, xfer, cfg_err, running;

  cpwm_timebase #(.W(W)) u_cpwm_timebase (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .xfer_mode(xfer_mode),
    .cnt_a(cnt_a), .cnt_b(cnt_b), .crest(crest), .trough(trough),
    .xfer(xfer), .cfg_err(cfg_err), .running(running)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [W-1:0] m_a = '0, m_b = '0, m_la = '0, m_lb = '0;
  logic [W-1:0] m_ba = '0, m_bb = '0, m_bd = '0;
  bit m_up = 1'b0, m_run = 1'b0;
  logic [W-1:0] s_a;
  bit s_crest;

  function automatic bit f_crest();
    return m_run && m_up && ((m_a >= m_la) || (m_b >= m_lb));
  endfunction
  function automatic bit f_trough();
    return m_run && !m_up && (m_b == '0);
  endfunction
  function automatic bit f_xfer(input logic [1:0] md);
    return (f_crest() && md[0]) || (f_trough() && md[1]);
  endfunction
  function automatic bit f_err();
    return m_ba != W'(m_bb + m_bd);
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic step(input bit st, input bit sp, input bit we,
                      input logic [1:0] sel, input logic [W-1:0] d);
    bit ec, et, ex, adv;
    @(negedge clk);
    start = st; stop = sp; wr_en = we; wr_sel = sel; wr_data = d; xfer_mode = mode_next;
    #1;
    ec = f_crest(); et = f_trough(); ex = f_xfer(xfer_mode);
    chk(cnt_a == m_a, "R3 cnt_a", cnt_a, m_a);
    chk(cnt_b == m_b, "R3 cnt_b", cnt_b, m_b);
    chk(crest == ec, "R4 crest", crest, ec);
    chk(trough == et, "R5 trough", trough, et);
    chk(xfer == ex, "R6 xfer", xfer, ex);
    chk(cfg_err == f_err(), "R9 cfg_err", cfg_err, f_err());
    chk(running == m_run, "R10 running", running, m_run);
    s_a = cnt_a; s_crest = crest;
    adv = m_run && !sp && !st;
    if (st || ex) begin m_la = m_ba; m_lb = m_bb; end
    if (st) begin
      m_a = m_bd; m_b = '0; m_up = 1'b1; m_run = 1'b1;
    end else begin
      if (sp) m_run = 1'b0;
      if (adv) begin
        if (ec) begin
          m_up = 1'b0;
          if (m_b != '0) begin m_a = m_a - 1'b1; m_b = m_b - 1'b1; end
        end else if (et || m_up) begin
          m_up = 1'b1; m_a = m_a + 1'b1; m_b = m_b + 1'b1;
        end else begin
          m_a = m_a - 1'b1; m_b = m_b - 1'b1;
        end
      end
    end
    if (we) begin
      case (sel)
        2'd0: m_ba = d;
        2'd1: m_bb = d;
        2'd2: m_bd = d;
        default: ;
      endcase
    end
  endtask

  task automatic idle();
    step(1'b0, 1'b0, 1'b0, 2'd0, '0);
  endtask
  task automatic wr(input logic [1:0] sel, input logic [W-1:0] d);
    step(1'b0, 1'b0, 1'b1, sel, d);
  endtask
  task automatic run_to_crest(output logic [W-1:0] pk);
    pk = '0;
    for (int i = 0; i < 500; i++) begin
      idle();
      if (s_crest) begin pk = s_a; break; end
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R3 watchdog act=%0d exp=%0d", 1, 0);
      summary();
      $finish;
    end
  end

  initial begin
    logic [W-1:0] pk, held;
    bit e;
    int r;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(cnt_a == '0 && cnt_b == '0, "R1 counters", cnt_a, 0);
    chk(!crest && !trough && !xfer, "R1 flags", {crest, trough, xfer}, 0);
    chk(!running, "R1 running", running, 0);
    rst_n = 1'b1;

    wr(2'd0, 12); wr(2'd1, 8); wr(2'd2, 4);
    mode_next = 2'b01;
    step(1'b1, 1'b0, 1'b0, 2'd0, '0);
    idle();
    chk(s_a == 4, "R2 start value", s_a, 4);

    wr(2'd0, 16); wr(2'd1, 12);
    run_to_crest(pk); chk(pk == 12, "R7 crest copy old peak", pk, 12);
    run_to_crest(pk); chk(pk == 16, "R7 crest copy next period", pk, 16);

    mode_next = 2'b10;
    wr(2'd0, 10); wr(2'd1, 6);
    run_to_crest(pk); chk(pk == 10, "R7 trough copy current period", pk, 10);

    mode_next = 2'b01;
    wr(2'd0, 16); wr(2'd1, 12);
    for (int i = 0; i < 500 && !f_crest(); i++) idle();
    wr(2'd0, 8);
    run_to_crest(pk); chk(pk == 16, "R8 write at copy not used", pk, 16);
    run_to_crest(pk); chk(pk == 8, "R8 write used at next copy", pk, 8);

    step(1'b0, 1'b1, 1'b0, 2'd0, '0);
    idle(); held = s_a;
    repeat (3) idle();
    chk(s_a == held, "R10 frozen", s_a, held);
    chk(!crest && !trough, "R10 flags low", {crest, trough}, 0);

    wr(2'd0, 16);
    step(1'b1, 1'b0, 1'b0, 2'd0, '0);
    idle();
    chk(s_a == 4, "R2 restart value", s_a, 4);

    e = cfg_err;
    wr(2'd3, 999);
    idle();
    chk(cfg_err == e, "R11 select 3 ignored", cfg_err, e);
    run_to_crest(pk); chk(pk == 16, "R11 limits untouched", pk, 16);

    mode_next = 2'b00;
    run_to_crest(pk); run_to_crest(pk);
    chk(pk == 16, "R6 mode 00 no copy", pk, 16);

    for (int n = 0; n < 4000; n++) begin
      r = $urandom % 100;
      if (r < 8) wr(2'd0, W'(5 + $urandom % 26));
      else if (r < 16) wr(2'd1, W'($urandom % 26));
      else if (r < 19) wr(2'd2, W'(1 + $urandom % 5));
      else if (r < 21) wr(2'd3, W'($urandom % 40));
      else if (r < 23) step(1'b0, 1'b1, 1'b0, 2'd0, '0);
      else if (r < 26) step(1'b1, 1'b0, 1'b0, 2'd0, '0);
      else if (r < 29) begin mode_next = 2'($urandom % 4); idle(); end
      else idle();
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule